// File: doc/BRIEF.md
# Dual-Bank GPIO With Per-Pin Output Source Selection

This peripheral drives 32 general-purpose pins split into two banks of 16. The upper bank (bits 31:16) faces the transmit-side daughterboard and the lower bank (bits 15:0) faces the receive-side daughterboard. Every pin has its own direction bit. An output pin takes its level from one of four sources: the software data register, the auto transmit/receive controller's output word, or one of two internal debug buses.

Software programs the block over a simple word-wide register bus with four registers at consecutive word offsets. Each register write replaces the whole 32-bit word. The pins are presented as split tristate signals: an output value and an output enable per pin, plus a per-pin input that reaches the read path through a two-stage synchronizer.

Top module: `gpio_srcmux_top`

## Requirements
- R1: Synchronous active-high reset clears the direction, both select registers and the software data register, so every `pad_oe` and `pad_out` bit is 0 and register reads at offsets 1, 2 and 3 return 0.
- R2: Writing the direction register (word offset 3) sets `pad_oe[n]` to bit n of the written word: 1 makes pin n an output and 0 makes it an input.
- R3: An output pin whose select field holds 0 drives `pad_out` with the matching bit of the software data register (written at word offset 0).
- R4: An output pin whose select field holds 1 drives the matching bit of `atr_word`, 2 drives the matching bit of `dbg_a`, and 3 drives the matching bit of `dbg_b`.
- R5: The select field for pin i of a bank sits at bits 2i+1:2i of that bank's select register; the register at word offset 1 governs pins 31:16 (field i controls pin 16+i), and the register at word offset 2 governs pins 15:0.
- R6: A pin whose direction bit is 0 has `pad_oe` low and `pad_out` low whatever its select field and source values hold.
- R7: A read at word offset 0 returns the pin inputs after a two-flop synchronizer: a change on `pad_in` ahead of a clock edge is not visible after that edge and is visible after the next, with pins 31:16 in the upper half.
- R8: Reads at word offsets 1, 2 and 3 return the last word written there; a read at offset 0 shows the synchronized pins, not the software data register.
- R9: A register changes only on a clock edge with `bus_wr` high and its offset on `bus_addr`, and such a write replaces all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Pin output levels |
| pad_oe | output | 32 | Pin output enables |
| atr_word | input | 32 | Auto transmit/receive controller output word |
| dbg_a | input | 32 | Debug source bus 0 |
| dbg_b | input | 32 | Debug source bus 1 |

## Verification
The source mux is driven with the three non-software sources held at patterns that differ bit by bit. Each whole-bank select value then picks out a pattern that no other source would give. A vector with all four codes packed into the low fields of both banks, in opposite orders, exposes swapped field positions and swapped banks. Vectors with half-bank and single-bit direction masks show that input pins stay quiet whatever their select fields and sources hold. A read sequence that samples one and two edges after a pin change confirms the synchronizer depth and the bank order of the read word.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int BANK_PINS = 16;
    localparam int NUM_BANKS = 2;
    localparam int SEL_W     = 2;
    localparam int OFS_W     = 2;
    localparam int NUM_REGS  = 1 << OFS_W;

    // per-pin output source code
    typedef enum logic [SEL_W-1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBGA = 2'd2,
        SRC_DBGB = 2'd3
    } src_sel_e;

    // register word offsets
    typedef enum logic [OFS_W-1:0] {
        OFS_DATA  = 2'd0,
        OFS_TXSEL = 2'd1,
        OFS_RXSEL = 2'd2,
        OFS_DIR   = 2'd3
    } reg_ofs_e;

    function automatic src_sel_e sel_field(input logic [SEL_W*BANK_PINS-1:0] word, input int idx);
        return src_sel_e'(word[SEL_W*idx +: SEL_W]);
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_mux_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [OFS_W-1:0]  addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] sw_q,
    output logic [WORD_W-1:0] txsel_q,
    output logic [WORD_W-1:0] rxsel_q,
    output logic [WORD_W-1:0] dir_q
);

    logic [WORD_W-1:0] regs [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[r] <= '0;
            else if (wr && (addr == OFS_W'(r)))
                regs[r] <= wdata;
        end
    end

    assign sw_q    = regs[OFS_DATA];
    assign txsel_q = regs[OFS_TXSEL];
    assign rxsel_q = regs[OFS_RXSEL];
    assign dir_q   = regs[OFS_DIR];

    // R9
    word_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == OFS_DIR) |=> (dir_q == $past(wdata)));

    // R9
    txsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == OFS_TXSEL) |=> $stable(txsel_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage[s] <= '0;
            else if (s == 0)
                stage[s] <= d;
            else
                stage[s] <= stage[(s > 0) ? s - 1 : 0];
        end
    end

    assign q = stage[STAGES-1];

    if (STAGES == 2) begin : g_chk
        logic [1:0] age;
        always_ff @(posedge clk) begin
            if (rst)
                age <= '0;
            else if (age != 2'd3)
                age <= age + 2'd1;
        end
        // R7
        sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2) |-> (q == $past(d, 2)));
    end

endmodule

// File: rtl/gpio_bank_mux.sv
module gpio_bank_mux
    import gpio_mux_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PINS-1:0]       dir,
    input  logic [SEL_W*PINS-1:0] sel,
    input  logic [PINS-1:0]       sw,
    input  logic [PINS-1:0]       atr,
    input  logic [PINS-1:0]       dbga,
    input  logic [PINS-1:0]       dbgb,
    output logic [PINS-1:0]       out,
    output logic [PINS-1:0]       oe
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        src_sel_e code;
        logic     pick;

        assign code = src_sel_e'(sel[SEL_W*i +: SEL_W]);

        always_comb begin
            unique case (code)
                SRC_SW:   pick = sw[i];
                SRC_ATR:  pick = atr[i];
                SRC_DBGA: pick = dbga[i];
                SRC_DBGB: pick = dbgb[i];
                default:  pick = 1'b0;
            endcase
        end

        assign out[i] = dir[i] & pick;
        assign oe[i]  = dir[i];

        // R6
        input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !oe[i] |-> !out[i]);

        // R4
        atr_route_chk: assert property (@(posedge clk) disable iff (rst)
            (oe[i] && code == SRC_ATR) |-> (out[i] == atr[i]));
    end

endmodule

// File: rtl/gpio_srcmux_top.sv
module gpio_srcmux_top
    import gpio_mux_pkg::*;
#(
    parameter int PINS_PER_BANK = BANK_PINS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [OFS_W-1:0]               bus_addr,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] bus_wdata,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] bus_rdata,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] atr_word,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] dbg_a,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] dbg_b
);

    localparam int WORD_W  = NUM_BANKS * PINS_PER_BANK;
    localparam int SELREGW = SEL_W * PINS_PER_BANK;

    logic [WORD_W-1:0] sw_q, txsel_q, rxsel_q, dir_q, pins_sync;

    gpio_regfile #(.WORD_W(WORD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .sw_q    (sw_q),
        .txsel_q (txsel_q),
        .rxsel_q (rxsel_q),
        .dir_q   (dir_q)
    );

    gpio_in_sync #(.W(WORD_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    // bank 0 (transmit side) sits in the upper half, bank 1 in the lower half
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BASE = (NUM_BANKS - 1 - b) * PINS_PER_BANK;
        logic [SELREGW-1:0] bank_sel;

        if (b == 0) begin : g_tx
            assign bank_sel = txsel_q[SELREGW-1:0];
        end else begin : g_rx
            assign bank_sel = rxsel_q[SELREGW-1:0];
        end

        gpio_bank_mux #(.PINS(PINS_PER_BANK)) u_mux (
            .clk  (clk),
            .rst  (rst),
            .dir  (dir_q[BASE +: PINS_PER_BANK]),
            .sel  (bank_sel),
            .sw   (sw_q[BASE +: PINS_PER_BANK]),
            .atr  (atr_word[BASE +: PINS_PER_BANK]),
            .dbga (dbg_a[BASE +: PINS_PER_BANK]),
            .dbgb (dbg_b[BASE +: PINS_PER_BANK]),
            .out  (pad_out[BASE +: PINS_PER_BANK]),
            .oe   (pad_oe[BASE +: PINS_PER_BANK])
        );
    end

    always_comb begin
        unique case (reg_ofs_e'(bus_addr))
            OFS_DATA:  bus_rdata = pins_sync;
            OFS_TXSEL: bus_rdata = txsel_q;
            OFS_RXSEL: bus_rdata = rxsel_q;
            OFS_DIR:   bus_rdata = dir_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R2
    dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata)));

endmodule

// File: tb/gpio_srcmux_top_test.sv
module gpio_srcmux_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic [31:0] atr_word = 32'h0F0F_0F0F;
    logic [31:0] dbg_a    = 32'h00FF_00FF;
    logic [31:0] dbg_b    = 32'h3333_3333;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_srcmux_top uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .atr_word(atr_word),
        .dbg_a(dbg_a), .dbg_b(dbg_b)
    );

    typedef struct packed {
        logic [31:0] dir;
        logic [31:0] tsel;
        logic [31:0] rsel;
        logic [31:0] sw;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h1234_5678, 32'h1234_5678},
        '{32'hFFFF_FFFF, 32'h5555_5555, 32'h5555_5555, 32'h1234_5678, 32'h0F0F_0F0F},
        '{32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h1234_5678, 32'h00FF_3333},
        '{32'hFFFF_FFFF, 32'h0000_00E4, 32'h0000_001B, 32'h0000_0000, 32'h0006_0007},
        '{32'h0000_FFFF, 32'h5555_5555, 32'h0000_0000, 32'hDEAD_BEEF, 32'h0000_BEEF},
        '{32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hCAFE_F00D, 32'hCAFE_0000},
        '{32'h8000_0001, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] ofs, input logic [31:0] val);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ofs; bus_wdata = val;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd_reg(input logic [1:0] ofs, output logic [31:0] val);
        bus_addr = ofs;
        #1;
        val = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        rd_reg(2'd1, rv); check("R1 txsel after reset", rv, 32'h0);
        rd_reg(2'd2, rv); check("R1 rxsel after reset", rv, 32'h0);
        rd_reg(2'd3, rv); check("R1 dir after reset", rv, 32'h0);

        // vector table: R2 R3 R4 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            wr_reg(2'd3, VECS[k].dir);
            wr_reg(2'd1, VECS[k].tsel);
            wr_reg(2'd2, VECS[k].rsel);
            wr_reg(2'd0, VECS[k].sw);
            check($sformatf("R3 R4 R5 R6 vector %0d pad_out", k), pad_out, VECS[k].exp);
            check($sformatf("R2 vector %0d pad_oe", k), pad_oe, VECS[k].dir);
        end

        // R8 readback; data offset shows pins, not software value
        rd_reg(2'd3, rv); check("R8 dir readback", rv, 32'h8000_0001);
        rd_reg(2'd2, rv); check("R8 rxsel readback", rv, 32'h0);
        rd_reg(2'd0, rv); check("R8 data read shows pins", rv, 32'h0);

        // R9 no write without strobe
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 32'h0000_0000; bus_wr = 1'b0;
        @(negedge clk);
        #1;
        check("R9 strobe low leaves pad_oe", pad_oe, 32'h8000_0001);
        rd_reg(2'd3, rv); check("R9 strobe low leaves dir", rv, 32'h8000_0001);

        // R9 full-word replace
        wr_reg(2'd3, 32'h0000_FFFF);
        check("R9 full word replaces dir", pad_oe, 32'h0000_FFFF);
        check("R9 full word pad_out", pad_out, 32'h0000_FFFF);

        // R7 synchronizer depth
        @(negedge clk);
        pad_in = 32'hA5A5_1234;
        rd_reg(2'd0, rv); check("R7 before edge", rv, 32'h0);
        @(negedge clk);
        rd_reg(2'd0, rv); check("R7 after one edge", rv, 32'h0);
        @(negedge clk);
        rd_reg(2'd0, rv); check("R7 after two edges", rv, 32'hA5A5_1234);
        pad_in = 32'hFFFF_0000;
        repeat (2) @(negedge clk);
        rd_reg(2'd0, rv); check("R7 upper half is transmit bank", rv, 32'hFFFF_0000);

        // R1 reset during operation
        wr_reg(2'd1, 32'h1234_5678);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 pad_oe after mid reset", pad_oe, 32'h0);
        check("R1 pad_out after mid reset", pad_out, 32'h0);
        rd_reg(2'd1, rv); check("R1 txsel after mid reset", rv, 32'h0);
        rd_reg(2'd3, rv); check("R1 dir after mid reset", rv, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule